// File: doc/BRIEF.md
# Serial EEPROM Boot Word Reader

This block sits behind the boot-ROM region of a generic memory bus and answers each 32-bit read by fetching four bytes from a large serial EEPROM. It uses a byte-level SMBus master to do this. A request carries a 19-bit byte address. The two low bits are dropped, so every request reads one aligned word. For each of the four bytes, the block runs a full random-read exchange on the serial bus. It first writes the address in three pieces, then does a repeated start and reads one byte back. The bytes are packed so that the bus sees the same word a 32-bit wide ROM would return.

A lost arbitration or a refused byte restarts that byte's exchange from its START. Fifteen failures on one byte end the request for good. The block then raises a sticky failure flag and never answers. The block reports activity on a plain busy pin. The boot-enable input gates new requests, so logic outside the block can switch boot mode off only while busy is low.

Requests use valid/ready: a request is taken on the clock edge where `req_valid` and `req_ready` are both high. `req_valid`, `req_addr` must be held until then. The response has no back-pressure: `rsp_valid` is a one-cycle pulse, and the consumer must capture `rsp_data` in that cycle. Commands to the serial master also use valid/ready. Each accepted command returns exactly one result pulse.

Top module: `smb_boot_bridge`

## Requirements
- R1: The device-address byte of a read sends {4'b1010, A[18:16], rw}, with rw in bit 0. A is the byte address. rw is 0 in the write phase and 1 in the read phase.
- R2: The write phase sends A[15:8] after the device address, then A[7:0].
- R3: Each byte read issues these commands in this order: START, WRITE dev+0, WRITE A[15:8], WRITE A[7:0], START, WRITE dev+1, READ, STOP. The op codes are START=0, WRITE=1, READ=2 and STOP=3.
- R4: The byte addresses read are B, B+1, B+2 and B+3, where B is `req_addr` with bits [1:0] cleared; bits [1:0] have no effect. The byte from B lands in `rsp_data[31:24]` and the byte from B+3 lands in [7:0].
- R5: Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide. That pulse comes one cycle after the result of the last STOP.
- R6: Result code 1 (arbitration lost) or 2 (NACK) restarts the current byte at its START. The 15th failure within one byte sets `fail` one cycle later. `fail` then stays high until reset, with no response and `busy` held high.
- R7: `req_ready` is high only when `boot_en` is high and no request is in progress. `busy` rises the cycle after acceptance and falls the cycle after the response pulse. While `boot_en` is low, no request is accepted and no command is issued.
- R8: A command stays valid with stable op and write data until `cmd_ready`. No new command is issued before the result (`res_valid`) of the previous one.
- R9: After reset, `req_ready` follows `boot_en`, and `rsp_valid`, `busy`, `fail` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Boot mode enable; gates acceptance of requests |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_addr | input | 19 | Byte address of the request; bits [1:0] ignored |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Assembled word, valid with rsp_valid |
| busy | output | 1 | Request in progress (or failed) |
| fail | output | 1 | Sticky retry-exhaustion flag |
| cmd_valid | output | 1 | Serial master command valid |
| cmd_ready | input | 1 | Serial master takes the command |
| cmd_op | output | 2 | Command: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| res_valid | input | 1 | Result pulse for the outstanding command |
| res_code | input | 2 | 0 done, 1 arbitration lost, 2 NACK |
| res_rdata | input | 8 | Byte received for READ |

## Verification
`busy` is due one cycle after the accepting edge. Each command is due in the cycle after the previous result. `rsp_valid` is due one cycle after the final STOP result, and `fail` one cycle after the fifteenth failure result. The bench drives and samples on the falling clock edge. It therefore sees every registered change half a cycle after the rising edge that makes it. The emulated serial master checks each command in the cycle of its handshake, against the byte address the bench computed for that position. Response words, pulse widths and busy/fail levels are compared in the falling-edge slot that follows the edge where they are due.

// File: rtl/smb_boot_pkg.sv
package smb_boot_pkg;
  localparam int ADDR_W  = 19;
  localparam int STEP_W  = 3;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } smb_op_e;

  typedef enum logic [1:0] {
    RC_DONE = 2'd0,
    RC_ARB  = 2'd1,
    RC_NACK = 2'd2,
    RC_RSVD = 2'd3
  } smb_rc_e;

  localparam logic [STEP_W-1:0] STEP_RD   = 3'd6;
  localparam logic [STEP_W-1:0] STEP_LAST = 3'd7;
endpackage

// File: rtl/smb_cmd_gen.sv
module smb_cmd_gen
  import smb_boot_pkg::*;
#(
  parameter logic [3:0] DEV_HI = 4'b1010
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] byte_addr,
  output smb_op_e           op,
  output logic [7:0]        wdata
);
  always_comb begin
    op    = OP_STOP;
    wdata = 8'h00;
    unique case (step)
      3'd0: op = OP_START;
      3'd1: begin op = OP_WRITE; wdata = {DEV_HI, byte_addr[18:16], 1'b0}; end
      3'd2: begin op = OP_WRITE; wdata = byte_addr[15:8]; end
      3'd3: begin op = OP_WRITE; wdata = byte_addr[7:0]; end
      3'd4: op = OP_START;
      3'd5: begin op = OP_WRITE; wdata = {DEV_HI, byte_addr[18:16], 1'b1}; end
      3'd6: op = OP_READ;
      default: op = OP_STOP;
    endcase
  end
endmodule

// File: rtl/smb_word_pack.sv
module smb_word_pack #(
  parameter int BYTES = 4,
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic [7:0]        din,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (shift) word <= {word[DATA_W-9:0], din};
  end
endmodule

// File: rtl/smb_retry_ctr.sv
module smb_retry_ctr #(
  parameter int MAX_TRIES = 15,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CNT_W'(MAX_TRIES - 1));
endmodule

// File: rtl/smb_boot_bridge.sv
module smb_boot_bridge
  import smb_boot_pkg::*;
#(
  parameter int         MAX_TRIES  = 15,
  parameter int         WORD_BYTES = 4,
  parameter logic [3:0] DEV_HI     = 4'b1010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_en,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [18:0] req_addr,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        busy,
  output logic        fail,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_wdata,
  input  logic        res_valid,
  input  logic [1:0]  res_code,
  input  logic [7:0]  res_rdata
);
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int DATA_W = 8 * WORD_BYTES;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_RESP, S_FAIL
  } state_e;

  state_e                    state_q;
  logic [ADDR_W-1:OFF_W]     base_q;
  logic [OFF_W-1:0]          off_q;
  logic [STEP_W-1:0]         step_q;
  logic [ADDR_W-1:0]         byte_addr;
  smb_op_e                   gen_op;
  logic [7:0]                gen_wdata;
  logic                      accept, res_ok, res_bad, retry_last;
  logic                      pack_clear, pack_shift, retry_clear;
  logic [DATA_W-1:0]         word;

  assign accept    = req_valid && req_ready;
  assign byte_addr = {base_q, off_q};
  assign res_ok    = (state_q == S_WAIT) && res_valid && (res_code == RC_DONE);
  assign res_bad   = (state_q == S_WAIT) && res_valid && (res_code != RC_DONE);

  smb_cmd_gen #(.DEV_HI(DEV_HI)) u_gen (
    .step      (step_q),
    .byte_addr (byte_addr),
    .op        (gen_op),
    .wdata     (gen_wdata)
  );

  assign pack_clear = accept;
  assign pack_shift = res_ok && (step_q == STEP_RD);

  smb_word_pack #(.BYTES(WORD_BYTES)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pack_clear),
    .shift (pack_shift),
    .din   (res_rdata),
    .word  (word)
  );

  assign retry_clear = accept || (res_ok && (step_q == STEP_LAST));

  smb_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (retry_clear),
    .bump  (res_bad),
    .last  (retry_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      off_q   <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          base_q  <= req_addr[ADDR_W-1:OFF_W];
          off_q   <= '0;
          step_q  <= '0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: if (cmd_ready) state_q <= S_WAIT;
        S_WAIT: begin
          if (res_ok) begin
            if (step_q == STEP_LAST) begin
              step_q <= '0;
              if (off_q == OFF_W'(WORD_BYTES - 1)) begin
                state_q <= S_RESP;
              end else begin
                off_q   <= off_q + 1'b1;
                state_q <= S_ISSUE;
              end
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= S_ISSUE;
            end
          end else if (res_bad) begin
            step_q  <= '0;
            state_q <= retry_last ? S_FAIL : S_ISSUE;
          end
        end
        S_RESP:  state_q <= S_IDLE;
        S_FAIL:  state_q <= S_FAIL;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = boot_en && (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign fail      = (state_q == S_FAIL);
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_data  = word;
  assign cmd_valid = (state_q == S_ISSUE);
  assign cmd_op    = gen_op;
  assign cmd_wdata = gen_wdata;
endmodule

// File: rtl/smb_boot_bridge_chk.sv
module smb_boot_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boot_en,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       busy,
  input logic       fail,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_wdata,
  input logic       res_valid
);
  p_ready_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (boot_en && !busy));

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_rsp_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));

  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

  p_fail_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!rsp_valid && busy && !cmd_valid));

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata)));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  p_no_cmd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_result_unblocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && busy && !fail) |=> !res_valid || cmd_valid || rsp_valid || fail || !busy);
endmodule

bind smb_boot_bridge smb_boot_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .boot_en   (boot_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .fail      (fail),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_wdata (cmd_wdata),
  .res_valid (res_valid)
);

// File: tb/smb_boot_bridge_bench.sv
module smb_boot_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [18:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        busy, fail;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_wdata;
  logic        res_valid = 1'b0;
  logic [1:0]  res_code = 2'd0;
  logic [7:0]  res_rdata = 8'h00;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int ncmd = 0;
  int fail_budget = 0;
  int rstep = 0;
  int r_off = 0;
  logic [18:0] exp_base = '0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  smb_boot_bridge u_smb_boot_bridge (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .fail(fail),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .res_valid(res_valid), .res_code(res_code),
    .res_rdata(res_rdata)
  );

  function automatic logic [7:0] mem(input logic [18:0] a);
    return 8'(a[7:0] * 8'd13) ^ a[15:8] ^ {a[18:16], a[18:14]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Emulated serial master and EEPROM
  initial begin
    logic [1:0]  op_c;
    logic [7:0]  wd_c;
    logic [18:0] ba;
    logic [1:0]  exp_op [8];
    exp_op = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd0, 2'd1, 2'd2, 2'd3};
    forever begin
      @(negedge clk);
      res_valid = 1'b0;
      if (cmd_valid && rst_n) begin
        op_c = cmd_op;
        wd_c = cmd_wdata;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        check("R8 hold", {cmd_op, cmd_wdata}, {op_c, wd_c});
        ncmd++;
        ba = exp_base + 19'(r_off);
        res_code = 2'd0;
        check("R3 order", 32'(op_c), 32'(exp_op[rstep]));
        case (rstep)
          1: check("R1 dev write", 32'(wd_c), 32'({4'b1010, ba[18:16], 1'b0}));
          2: check("R2 high byte", 32'(wd_c), 32'(ba[15:8]));
          3: check("R2 low byte", 32'(wd_c), 32'(ba[7:0]));
          5: check("R1 dev read", 32'(wd_c), 32'({4'b1010, ba[18:16], 1'b1}));
          6: res_rdata = mem(ba);
          default: ;
        endcase
        if (rstep == 1 && fail_budget > 0) begin
          res_code = (fail_budget % 2 == 1) ? 2'd1 : 2'd2;
          fail_budget--;
          rstep = 0;
        end else if (rstep == 7) begin
          rstep = 0;
          r_off++;
        end else begin
          rstep++;
        end
        res_valid = 1'b1;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rstep = 0;
    r_off = 0;
    fail_budget = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_word(input logic [18:0] a, input bit expect_fail);
    logic [18:0] b;
    logic [31:0] exp;
    int waited;
    bit seen;
    b = {a[18:2], 2'b00};
    exp = {mem(b), mem(b + 19'd1), mem(b + 19'd2), mem(b + 19'd3)};
    exp_base = b;
    r_off = 0;
    rstep = 0;
    req_addr = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 busy after accept", 32'(busy), 32'd1);
    seen = 1'b0;
    waited = 0;
    while (!seen && waited < 900) begin
      if (rsp_valid) seen = 1'b1;
      else begin @(negedge clk); waited++; end
    end
    if (expect_fail) begin
      check("R6 no response", 32'(seen), 32'd0);
      check("R6 fail flag", 32'(fail), 32'd1);
      check("R6 busy held", 32'(busy), 32'd1);
      check("R7 ready low on fail", 32'(req_ready), 32'd0);
    end else begin
      check("R5 response seen", 32'(seen), 32'd1);
      check("R4 word", rsp_data, exp);
      @(negedge clk);
      check("R5 pulse width", 32'(rsp_valid), 32'd0);
      check("R7 busy drop", 32'(busy), 32'd0);
      check("R6 no fail", 32'(fail), 32'd0);
    end
  endtask

  initial begin
    int snap;
    repeat (2) @(negedge clk);
    check("R9 ready in reset", 32'(req_ready), 32'd1);
    check("R9 rsp/busy/fail/cmd", {rsp_valid, busy, fail, cmd_valid}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", 32'(req_ready), 32'd1);

    // sweep every device-select value, with ignored low bits varied
    for (int d = 0; d < 8; d++) begin
      for (int k = 0; k < 4; k++) begin
        read_word({3'(d), 16'(k * 16'h4F1C + d * 16'h1234), 2'(k)}[18:0], 1'b0);
      end
    end
    read_word(19'h00000, 1'b0);
    read_word(19'h7FFFF, 1'b0);
    check("R4 low bits ignored", 32'(exp_base), 32'h7FFFC);

    // R6: 14 failures within one byte still complete
    fail_budget = 14;
    read_word(19'h2A5D4, 1'b0);
    check("R6 budget consumed", 32'(fail_budget), 32'd0);

    // R6: 15 failures end the request
    fail_budget = 15;
    read_word(19'h13570, 1'b1);
    repeat (20) @(negedge clk);
    check("R6 fail sticky", 32'(fail), 32'd1);
    do_reset();
    check("R9 fail cleared", 32'({fail, busy}), 32'd0);

    // R7: boot disabled blocks acceptance
    boot_en = 1'b0;
    snap = ncmd;
    req_addr = 19'h0ABC8;
    req_valid = 1'b1;
    repeat (20) begin
      @(negedge clk);
      check("R7 ready gated", 32'({req_ready, busy}), 32'd0);
    end
    check("R7 no commands", 32'(ncmd), 32'(snap));
    req_valid = 1'b0;
    boot_en = 1'b1;
    @(negedge clk);
    read_word(19'h0ABC8, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule